// File: doc/BRIEF.md
# Unrounded Fused Multiply-Add Core

This block is the arithmetic heart of a double-precision fused multiply-add. It computes z + x·y for finite, nonzero operands that are already normalised. Each operand comes in as a sign, an unbiased signed exponent and a 53-bit mantissa with the leading one present. The product is formed exactly, reduced to 56 bits with a sticky bit, aligned against z, and then added or subtracted. Nothing is rounded here. The result is a sign, an exponent and a 56-bit mantissa whose low three bits are guard, round and sticky. A later stage rounds and packs it.

The core is a small state machine. In ST_IDLE it accepts one operation when `in_valid` is high. ST_MUL forms and reduces the product. ST_ALIGN shifts the operand with the smaller exponent. ST_ADD adds or subtracts. ST_NORM shifts the difference left one bit per cycle. ST_DONE presents the result. The transitions are:

- IDLE→MUL on `in_valid`.
- MUL→ALIGN and ALIGN→ADD always.
- ADD→DONE for a sum or an exact zero.
- ADD→NORM for a nonzero difference.
- NORM→DONE once bit 55 is set. NORM stays in NORM otherwise.
- DONE→IDLE on `out_ready`.

Top module: `fmac_unrounded`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: The product sign is the XOR of the x and y signs. The product exponent is the sum of the x and y exponents, plus one when the exact mantissa product is 2 or more. The reduced product always has bit 55 set.
- R3: Bits of the exact 106-bit product that fall below the 56-bit window are ORed into bit 0 of the product mantissa.
- R4: The operand with the smaller exponent is shifted right by the exponent difference. The bits shifted out are ORed into bit 0, and the result takes the larger exponent. A shift of 56 or more leaves only bit 0, equal to the OR of all the operand's bits.
- R5: With equal signs the mantissas are added. A carry out of bit 55 shifts the sum right by one, keeps the dropped bit in bit 0, and adds one to the exponent.
- R6: With different signs the smaller mantissa is subtracted from the larger, and the result takes the sign of the larger.
- R7: An exactly zero difference gives mantissa 0 and exponent 0, with sign equal to `round_down` (1 means rounding toward minus infinity).
- R8: A nonzero difference is shifted left until bit 55 is set, and the exponent drops by one for each shift. Every presented nonzero result has bit 55 set.
- R9: `in_ready` is high only in ST_IDLE, so inputs offered while busy are ignored. A presented result stays stable with `out_valid` high until `out_ready` is seen. `in_ready` returns on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Core idle, operation accepted this cycle if offered |
| x_sign | input | 1 | Sign of multiplicand x |
| x_exp | input | EXP_W (12) | Unbiased signed exponent of x |
| x_mant | input | MANT_W (53) | Mantissa of x, bit 52 set |
| y_sign | input | 1 | Sign of multiplier y |
| y_exp | input | EXP_W (12) | Unbiased signed exponent of y |
| y_mant | input | MANT_W (53) | Mantissa of y, bit 52 set |
| z_sign | input | 1 | Sign of addend z |
| z_exp | input | EXP_W (12) | Unbiased signed exponent of z |
| z_mant | input | MANT_W (53) | Mantissa of z, bit 52 set |
| round_down | input | 1 | Rounding toward minus infinity is selected |
| out_valid | output | 1 | Result presented |
| out_ready | input | 1 | Downstream takes the result |
| res_sign | output | 1 | Result sign |
| res_exp | output | EXP_W+2 (14) | Result exponent, signed |
| res_mant | output | MANT_W+3 (56) | Result mantissa, bit 55 leading, bits 2:0 guard/round/sticky |

## Verification
The checks on product normalisation and on the leading bit of results rely on every mantissa arriving with bit 52 set. They also rely on the exponents being small enough that the product and alignment sums fit the widened exponent. Every stimulus vector uses mantissas with the leading one present and exponents well inside the 12-bit range. The vectors also exercise:

- alignment shifts both above and below the 56-bit window;
- a product that is all ones, which forces sticky collection;
- a near-total cancellation that needs 52 normalisation steps.

Operands offered while the core is busy are withdrawn before the result is released. This keeps the ignored-input check separate from the next accepted operation.

// File: rtl/fmac_pkg.sv
package fmac_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MUL,
        ST_ALIGN,
        ST_ADD,
        ST_NORM,
        ST_DONE
    } fmac_state_e;
endpackage

// File: rtl/fmac_sticky_shr.sv
module fmac_sticky_shr #(
    parameter int W    = 56,
    parameter int SH_W = 14
) (
    input  logic [W-1:0]    din,
    input  logic [SH_W-1:0] amt,
    output logic [W-1:0]    dout
);
    logic [W-1:0] lost_mask;
    logic         lost;

    always_comb begin
        lost_mask = '0;
        lost      = 1'b0;
        if (32'(amt) >= W) begin
            dout = {{(W-1){1'b0}}, |din};
        end else begin
            lost_mask = ~({W{1'b1}} << amt);
            lost      = |(din & lost_mask);
            dout      = (din >> amt) | {{(W-1){1'b0}}, lost};
        end
    end
endmodule

// File: rtl/fmac_mul.sv
module fmac_mul #(
    parameter int MANT_W = 53,
    parameter int HALF_W = 32,
    parameter int EXP_W  = 12,
    parameter int EXP_O  = EXP_W + 2,
    parameter int RES_W  = MANT_W + 3
) (
    input  logic [MANT_W-1:0]       xm,
    input  logic [MANT_W-1:0]       ym,
    input  logic signed [EXP_W-1:0] xe,
    input  logic signed [EXP_W-1:0] ye,
    output logic [RES_W-1:0]        prod_m,
    output logic signed [EXP_O-1:0] prod_e
);
    localparam int WORD_W = 2 * HALF_W;
    localparam int FULL_W = 2 * WORD_W;
    localparam int JUST   = WORD_W - MANT_W;
    localparam int SH_HI  = WORD_W - RES_W;
    localparam int SH_LO  = SH_HI - 1;
    localparam int EXT    = EXP_O - EXP_W;

    logic [WORD_W-1:0] xw, yw;
    logic [WORD_W-1:0] pp [2][2];
    logic [FULL_W-1:0] full;
    logic [WORD_W-1:0] hs;

    assign xw = WORD_W'(xm) << JUST;
    assign yw = WORD_W'(ym) << JUST;

    for (genvar i = 0; i < 2; i++) begin : g_xh
        for (genvar j = 0; j < 2; j++) begin : g_yh
            assign pp[i][j] = WORD_W'(xw[i*HALF_W +: HALF_W]) * WORD_W'(yw[j*HALF_W +: HALF_W]);
        end
    end

    always_comb begin
        full = '0;
        for (int i = 0; i < 2; i++) begin
            for (int j = 0; j < 2; j++) begin
                full = full + (FULL_W'(pp[i][j]) << (HALF_W * (i + j)));
            end
        end
        hs = full[FULL_W-1:WORD_W];
        hs[0] = hs[0] | (|full[WORD_W-1:0]);
        if (hs[WORD_W-1]) begin
            prod_m = hs[WORD_W-1:SH_HI];
            prod_m[0] = prod_m[0] | (|hs[SH_HI-1:0]);
            prod_e = {{EXT{xe[EXP_W-1]}}, xe} + {{EXT{ye[EXP_W-1]}}, ye} + EXP_O'(1);
        end else begin
            prod_m = hs[WORD_W-2:SH_LO];
            prod_m[0] = prod_m[0] | (|hs[SH_LO-1:0]);
            prod_e = {{EXT{xe[EXP_W-1]}}, xe} + {{EXT{ye[EXP_W-1]}}, ye};
        end
    end
endmodule

// File: rtl/fmac_unrounded.sv
module fmac_unrounded #(
    parameter int MANT_W = 53,
    parameter int HALF_W = 32,
    parameter int EXP_W  = 12,
    parameter int EXP_O  = EXP_W + 2,
    parameter int RES_W  = MANT_W + 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic                    x_sign,
    input  logic signed [EXP_W-1:0] x_exp,
    input  logic [MANT_W-1:0]       x_mant,
    input  logic                    y_sign,
    input  logic signed [EXP_W-1:0] y_exp,
    input  logic [MANT_W-1:0]       y_mant,
    input  logic                    z_sign,
    input  logic signed [EXP_W-1:0] z_exp,
    input  logic [MANT_W-1:0]       z_mant,
    input  logic                    round_down,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic                    res_sign,
    output logic signed [EXP_O-1:0] res_exp,
    output logic [RES_W-1:0]        res_mant
);
    import fmac_pkg::*;

    localparam int EXT   = EXP_O - EXP_W;
    localparam int GRS_W = RES_W - MANT_W;

    fmac_state_e state, state_nx;

    // captured operands
    logic                    op_xs, op_ys, op_zs, op_rd;
    logic signed [EXP_W-1:0] op_xe, op_ye, op_ze;
    logic [MANT_W-1:0]       op_xm, op_ym, op_zm;
    // working registers
    logic                    p_s;
    logic signed [EXP_O-1:0] p_e, z_e, acc_e;
    logic [RES_W-1:0]        p_m, z_m, acc_m;
    logic                    acc_s;

    // combinational datapath
    logic [RES_W-1:0]        mul_m;
    logic signed [EXP_O-1:0] mul_e;
    logic signed [EXP_O-1:0] e_diff;
    logic                    z_bigger;
    logic [EXP_O-1:0]        sh_amt;
    logic [RES_W-1:0]        sh_in, sh_out;
    logic [RES_W:0]          sum_w;
    logic                    z_ge;
    logic [RES_W-1:0]        dif_m;

    fmac_mul #(
        .MANT_W(MANT_W), .HALF_W(HALF_W), .EXP_W(EXP_W), .EXP_O(EXP_O), .RES_W(RES_W)
    ) u_mul (
        .xm(op_xm), .ym(op_ym), .xe(op_xe), .ye(op_ye),
        .prod_m(mul_m), .prod_e(mul_e)
    );

    assign e_diff   = z_e - p_e;
    assign z_bigger = (e_diff > 0);
    assign sh_amt   = z_bigger ? e_diff : -e_diff;
    assign sh_in    = z_bigger ? p_m : z_m;

    fmac_sticky_shr #(.W(RES_W), .SH_W(EXP_O)) u_shr (
        .din(sh_in), .amt(sh_amt), .dout(sh_out)
    );

    // p_m / z_m hold the aligned values in ST_ADD
    assign sum_w = {1'b0, p_m} + {1'b0, z_m};
    assign z_ge  = (z_m >= p_m);
    assign dif_m = z_ge ? (z_m - p_m) : (p_m - z_m);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (in_valid) state_nx = ST_MUL;
            ST_MUL:   state_nx = ST_ALIGN;
            ST_ALIGN: state_nx = ST_ADD;
            ST_ADD:   begin
                if (p_s == op_zs || dif_m == '0) state_nx = ST_DONE;
                else                             state_nx = ST_NORM;
            end
            ST_NORM:  if (acc_m[RES_W-1]) state_nx = ST_DONE;
            ST_DONE:  if (out_ready) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_xs <= 1'b0; op_ys <= 1'b0; op_zs <= 1'b0; op_rd <= 1'b0;
            op_xe <= '0;   op_ye <= '0;   op_ze <= '0;
            op_xm <= '0;   op_ym <= '0;   op_zm <= '0;
            p_s   <= 1'b0; p_e <= '0; z_e <= '0; p_m <= '0; z_m <= '0;
            acc_s <= 1'b0; acc_e <= '0; acc_m <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (in_valid) begin
                    op_xs <= x_sign; op_ys <= y_sign; op_zs <= z_sign; op_rd <= round_down;
                    op_xe <= x_exp;  op_ye <= y_exp;  op_ze <= z_exp;
                    op_xm <= x_mant; op_ym <= y_mant; op_zm <= z_mant;
                end
                ST_MUL: begin
                    p_s <= op_xs ^ op_ys;
                    p_m <= mul_m;
                    p_e <= mul_e;
                    z_m <= {op_zm, {GRS_W{1'b0}}};
                    z_e <= {{EXT{op_ze[EXP_W-1]}}, op_ze};
                end
                ST_ALIGN: begin
                    if (z_bigger) begin
                        p_m   <= sh_out;
                        acc_e <= z_e;
                    end else begin
                        z_m   <= sh_out;
                        acc_e <= p_e;
                    end
                end
                ST_ADD: begin
                    if (p_s == op_zs) begin
                        acc_s <= p_s;
                        if (sum_w[RES_W]) begin
                            acc_m <= sum_w[RES_W:1] | {{(RES_W-1){1'b0}}, sum_w[0]};
                            acc_e <= acc_e + EXP_O'(1);
                        end else begin
                            acc_m <= sum_w[RES_W-1:0];
                        end
                    end else if (dif_m == '0) begin
                        acc_s <= op_rd;
                        acc_e <= '0;
                        acc_m <= '0;
                    end else begin
                        acc_s <= z_ge ? op_zs : p_s;
                        acc_m <= dif_m;
                    end
                end
                ST_NORM: if (!acc_m[RES_W-1]) begin
                    acc_m <= acc_m << 1;
                    acc_e <= acc_e - EXP_O'(1);
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    assign in_ready  = (state == ST_IDLE);
    assign out_valid = (state == ST_DONE);
    assign res_sign  = acc_s;
    assign res_exp   = acc_e;
    assign res_mant  = acc_m;

    // the reduced product always leads with bit 55
    assert_prod_lead_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ALIGN) |-> p_m[RES_W-1]);

    // zero result carries the rounding-mode sign
    assert_zero_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && res_mant == '0) |-> (res_exp == '0 && res_sign == op_rd));

    // presented results are normalised
    assert_norm_lead_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (res_mant[RES_W-1] || res_mant == '0));

    // result held while downstream stalls
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(res_mant) && $stable(res_exp) && $stable(res_sign)));

    // accepting an operation makes the core busy
    assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!in_ready && !out_valid));
endmodule

// File: tb/sim_fmac_unrounded.sv
module sim_fmac_unrounded;
    localparam int MANT_W = 53;
    localparam int EXP_W  = 12;
    localparam int EXP_O  = EXP_W + 2;
    localparam int RES_W  = MANT_W + 3;
    localparam int N      = 10;

    localparam logic [MANT_W-1:0] ONE  = 53'h10_0000_0000_0000;
    localparam logic [MANT_W-1:0] ONEH = 53'h18_0000_0000_0000;
    localparam logic [MANT_W-1:0] ONEP = 53'h10_0000_0000_0001;
    localparam logic [MANT_W-1:0] ALL1 = 53'h1F_FFFF_FFFF_FFFF;
    localparam logic [RES_W-1:0]  M80  = 56'h80_0000_0000_0000;

    // case: 0 carry, 1 exp sum, 2/3 zero, 4 norm, 5 z larger, 6 far, 7 near sticky, 8 product sticky, 9 long norm
    localparam logic              T_XS [N] = '{0, 0, 0, 0, 0, 1, 0, 0, 1, 0};
    localparam logic signed [11:0] T_XE [N] = '{0, 3, 0, 0, 0, 0, 0, 0, 0, 0};
    localparam logic [52:0]       T_XM [N] = '{ONE, ONEH, ONE, ONE, ONEH, ONE, ONE, ONEP, ALL1, ONE};
    localparam logic              T_YS [N] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 0};
    localparam logic signed [11:0] T_YE [N] = '{0, -5, 0, 0, 0, 0, 0, 0, 0, 0};
    localparam logic [52:0]       T_YM [N] = '{ONE, ONEH, ONE, ONE, ONE, ONE, ONE, ONE, ALL1, ONE};
    localparam logic              T_ZS [N] = '{0, 0, 1, 1, 1, 0, 0, 0, 0, 1};
    localparam logic signed [11:0] T_ZE [N] = '{0, -2, 0, 0, 0, 1, 100, 4, -200, 0};
    localparam logic [52:0]       T_ZM [N] = '{ONE, ONE, ONE, ONE, ONE, ONEH, ONE, ONE, ONE, ONEP};
    localparam logic              T_RD [N] = '{0, 0, 0, 1, 0, 0, 0, 0, 0, 0};
    localparam logic              E_S  [N] = '{0, 0, 0, 1, 0, 0, 0, 0, 0, 1};
    localparam logic signed [13:0] E_E [N] = '{1, -1, 0, 0, -1, 1, 100, 4, 1, -52};
    localparam logic [55:0]       E_M  [N] = '{M80, 56'hD0_0000_0000_0000, 56'h0, 56'h0, M80, M80,
                                               56'h80_0000_0000_0001, 56'h88_0000_0000_0001,
                                               56'hFF_FFFF_FFFF_FFF2, M80};
    localparam string             T_REQ [N] = '{"R5", "R2", "R7", "R7", "R8", "R6", "R4", "R4", "R3", "R8"};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, out_ready = 1'b1, round_down = 1'b0;
    logic x_sign = 1'b0, y_sign = 1'b0, z_sign = 1'b0;
    logic signed [EXP_W-1:0] x_exp = '0, y_exp = '0, z_exp = '0;
    logic [MANT_W-1:0] x_mant = ONE, y_mant = ONE, z_mant = ONE;
    logic in_ready, out_valid, res_sign;
    logic signed [EXP_O-1:0] res_exp;
    logic [RES_W-1:0] res_mant;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    fmac_unrounded u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .x_sign(x_sign), .x_exp(x_exp), .x_mant(x_mant),
        .y_sign(y_sign), .y_exp(y_exp), .y_mant(y_mant),
        .z_sign(z_sign), .z_exp(z_exp), .z_mant(z_mant),
        .round_down(round_down), .out_valid(out_valid), .out_ready(out_ready),
        .res_sign(res_sign), .res_exp(res_exp), .res_mant(res_mant)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic load(input int k);
        x_sign = T_XS[k]; x_exp = T_XE[k]; x_mant = T_XM[k];
        y_sign = T_YS[k]; y_exp = T_YE[k]; y_mant = T_YM[k];
        z_sign = T_ZS[k]; z_exp = T_ZE[k]; z_mant = T_ZM[k];
        round_down = T_RD[k];
    endtask

    // offers the loaded operands and waits (at negedge) until out_valid
    task automatic issue_and_wait(input string req);
        int n;
        @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        n = 0;
        while (!out_valid && n < 200) begin
            @(negedge clk);
            n++;
        end
        if (!out_valid) chk(1'b0, req, "timeout", 64'(n), 64'd0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_valid == 1'b0, "R1", "out_valid", 64'(out_valid), 64'd0);
        chk(in_ready == 1'b1, "R1", "in_ready", 64'(in_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // table of vectors
        for (int k = 0; k < N; k++) begin
            load(k);
            issue_and_wait(T_REQ[k]);
            chk(res_sign == E_S[k], T_REQ[k], "sign", 64'(res_sign), 64'(E_S[k]));
            chk(res_exp == E_E[k], T_REQ[k], "exp", 64'(res_exp), 64'(E_E[k]));
            chk(res_mant == E_M[k], T_REQ[k], "mant", 64'(res_mant), 64'(E_M[k]));
        end

        // R9: stall, ignored inputs, release
        @(negedge clk);
        out_ready = 1'b0;
        load(0);
        issue_and_wait("R9");
        load(4);
        in_valid = 1'b1;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk(out_valid == 1'b1, "R9", "held valid", 64'(out_valid), 64'd1);
            chk(in_ready == 1'b0, "R9", "busy in_ready", 64'(in_ready), 64'd0);
            chk(res_mant == M80 && res_exp == 14'sd1, "R9", "held result",
                64'(res_mant), 64'(M80));
        end
        in_valid = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R9", "valid after take", 64'(out_valid), 64'd0);
        chk(in_ready == 1'b1, "R9", "ready after take", 64'(in_ready), 64'd1);
        repeat (8) @(negedge clk);
        chk(out_valid == 1'b0, "R9", "ignored op produced nothing", 64'(out_valid), 64'd0);

        // R1: reset mid-operation returns to idle
        load(9);
        @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R1", "reset mid-op",
            64'({in_ready, out_valid}), 64'b10);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule